// File: doc/BRIEF.md
# Self-Invalidating Word-State Cache Controller

This block is the private, per-core cache controller of a coherence scheme in which nothing outside the core ever invalidates its copies. Every word held in the cache has a stable state of its own: Invalid, Valid or Registered. There are no transient states. A store marks the word Registered and sends a one-cycle registration notice to the shared level. A load that finds its word Invalid sends a line read request and waits for the fill. Loads to Valid or Registered words hit. Each word also carries a region identifier and a touched bit. The touched bit records that the word was read during the current phase.

At a phase boundary the core starts a sweep with a mask of the regions that other cores may have written. The sweep visits one line per cycle. It drops every Valid word that sits in a masked region and was not touched. Registered and touched words survive. At the end the sweep clears all touched bits and gives a done pulse. Lines hold a single tag and are allocated and filled whole. A fill only writes words that are Invalid, so a word the core registered is never overwritten by line-grained traffic. The line chosen on a miss is fixed by the address index; choosing a victim and serving the shared side are handled elsewhere.

Top module: `sinv_l1_ctrl`

## Requirements
- R1: After reset every word is Invalid, `req_ready_o` is 1, and `rsp_valid_o`, `rd_req_valid_o`, `reg_valid_o` and `sweep_done_o` are 0. Addresses are word addresses: bits [OFF_W-1:0] select the word in a line, the next IDX_W bits select the line, and the remaining upper bits form the tag.
- R2: A load whose word is Invalid, or whose line holds another tag, raises `rd_req_valid_o` for one cycle, in the cycle after the load is accepted, with `rd_req_line_o` equal to the address without its word-offset bits. On the cycle after `fill_valid_i`, `rsp_valid_o` is 1 and `rsp_data_o` holds the requested word. The filled words become Valid.
- R3: A load to a Valid or Registered word gives `rsp_valid_o` with the stored data in the cycle after acceptance, and no read request.
- R4: A store, from any state, makes the word Registered with the new data and region. In the next cycle it pulses `reg_valid_o` with `reg_addr_o` and `reg_data_o` equal to the store's address and data.
- R5: A fill writes only the words of the line that are Invalid. Fill word w is taken from `fill_data_i[w*DATA_W +: DATA_W]`, and its region from `fill_region_i[w*RGN_W +: RGN_W]`. Valid and Registered words keep their data.
- R6: A load or store whose tag differs from the tag of the indexed line reallocates that line. The new tag is installed and every other word of the line becomes Invalid.
- R7: A sweep turns a word Invalid only if it is Valid, untouched, and bit r of `sweep_mask_i` is set, where r is the word's region. Registered words, touched words and words of unmasked regions are kept. Internally the word state is 2 bits: 00 Invalid, 01 Valid, 10 Registered.
- R8: A sweep handles one line per cycle. `sweep_done_o` pulses for one cycle, NUM_LINES cycles after the cycle in which the sweep was accepted.
- R9: When a sweep completes, all touched bits are cleared. A word that was read only in an earlier phase is dropped by the next sweep whose mask covers its region.
- R10: While a sweep is running or pending, and while a miss is outstanding, `req_ready_o` is 0. A sweep start and a request in the same cycle: the sweep goes first and the request is accepted after done. A sweep start during an outstanding miss is held until the fill completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_write_i | input | 1 | 1 for store, 0 for load |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Store data |
| req_region_i | input | RGN_W | Region of the stored word |
| req_ready_o | output | 1 | Request accepted when valid and ready |
| rsp_valid_o | output | 1 | Load data valid |
| rsp_data_o | output | DATA_W | Load data |
| rd_req_valid_o | output | 1 | Line read request pulse |
| rd_req_line_o | output | ADDR_W-OFF_W | Line address of the read request |
| fill_valid_i | input | 1 | Line fill arrives |
| fill_data_i | input | WORDS*DATA_W | Fill data, word w at w*DATA_W |
| fill_region_i | input | WORDS*RGN_W | Fill region ids, word w at w*RGN_W |
| reg_valid_o | output | 1 | Registration notice pulse |
| reg_addr_o | output | ADDR_W | Registered word address |
| reg_data_o | output | DATA_W | Registered word data |
| sweep_start_i | input | 1 | Start a phase-end sweep |
| sweep_mask_i | input | NUM_REGIONS | Writable-region mask, held during the sweep |
| sweep_done_o | output | 1 | Sweep complete pulse |

## Verification
The sweep sequencer and the request path can both claim the same cycle. This happens when a sweep start arrives in the same cycle as a load, and when it arrives while a miss waits for its fill. The bench provokes the first case by raising both together and holding the load. It passes only if the done pulse is seen before any response and the delayed load then returns the data of a Registered word. It provokes the second case by pulsing the start during the miss. It checks that the fill still completes with correct data, that ready stays low while the sweep is pending, and that the deferred sweep then runs and drops an untouched word.

// File: rtl/sinv_pkg.sv
package sinv_pkg;
  typedef enum logic [1:0] {
    WS_INV = 2'b00,
    WS_VAL = 2'b01,
    WS_REG = 2'b10
  } wstate_e;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_WAIT = 1'b1
  } ctrl_e;
endpackage

// File: rtl/sinv_sweep_seq.sv
module sinv_sweep_seq #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] line_o,
  output logic             last_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_LINE = IDX_W'(NUM_LINES - 1);

  logic             busy_q, done_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (cnt_q == LAST_LINE) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign line_o = cnt_q;
  assign last_o = busy_q && (cnt_q == LAST_LINE);
  assign done_o = done_q;

  a_r8_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(last_o));
  a_r8_one_line_per_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o) |=> (busy_o && line_o == IDX_W'($past(line_o) + 1'b1)));
endmodule

// File: rtl/sinv_line.sv
module sinv_line
  import sinv_pkg::*;
#(
  parameter int unsigned WORDS       = 4,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned TAG_W       = 5,
  parameter int unsigned NUM_REGIONS = 4,
  localparam int unsigned OFF_W = $clog2(WORDS),
  localparam int unsigned RGN_W = $clog2(NUM_REGIONS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           alloc_i,
  input  logic [TAG_W-1:0]               tag_i,
  input  logic                           fill_i,
  input  logic [WORDS*DATA_W-1:0]        fill_data_i,
  input  logic [WORDS*RGN_W-1:0]         fill_rgn_i,
  input  logic                           store_i,
  input  logic                           touch_i,
  input  logic [OFF_W-1:0]               word_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [RGN_W-1:0]               wrgn_i,
  input  logic                           sweep_i,
  input  logic [NUM_REGIONS-1:0]         mask_i,
  input  logic                           clr_touch_i,
  output logic [TAG_W-1:0]               tag_o,
  output logic [WORDS-1:0][1:0]          state_o,
  output logic [WORDS-1:0][DATA_W-1:0]   data_o
);
  logic [TAG_W-1:0]  tag_q;
  wstate_e           st_q  [WORDS];
  logic [WORDS-1:0]  tch_q;
  logic [RGN_W-1:0]  rgn_q [WORDS];
  logic [DATA_W-1:0] dat_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      tch_q <= '0;
      for (int w = 0; w < WORDS; w++) begin
        st_q[w]  <= WS_INV;
        rgn_q[w] <= '0;
        dat_q[w] <= '0;
      end
    end else begin
      if (alloc_i) tag_q <= tag_i;
      for (int w = 0; w < WORDS; w++) begin
        if (alloc_i) begin
          st_q[w]  <= WS_INV;
          tch_q[w] <= 1'b0;
        end
        // merge: a fill never overwrites a live word of the same tag
        if (fill_i && (alloc_i || st_q[w] == WS_INV)) begin
          st_q[w]  <= WS_VAL;
          dat_q[w] <= fill_data_i[w*DATA_W +: DATA_W];
          rgn_q[w] <= fill_rgn_i[w*RGN_W +: RGN_W];
        end
        if (store_i && word_i == OFF_W'(w)) begin
          st_q[w]  <= WS_REG;
          dat_q[w] <= wdata_i;
          rgn_q[w] <= wrgn_i;
        end
        if (touch_i && word_i == OFF_W'(w)) tch_q[w] <= 1'b1;
        if (sweep_i && st_q[w] == WS_VAL && !tch_q[w] && mask_i[rgn_q[w]])
          st_q[w] <= WS_INV;
        if (clr_touch_i) tch_q[w] <= 1'b0;
      end
    end
  end

  assign tag_o = tag_q;

  for (genvar w = 0; w < WORDS; w++) begin : g_out
    assign state_o[w] = st_q[w];
    assign data_o[w]  = dat_q[w];

    a_r7_registered_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sweep_i && st_q[w] == WS_REG) |=> (st_q[w] == WS_REG));
    a_r7_touched_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sweep_i && st_q[w] == WS_VAL && tch_q[w]) |=> (st_q[w] == WS_VAL));
    a_r9_touch_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_touch_i |=> !tch_q[w]);
  end
endmodule

// File: rtl/sinv_l1_ctrl.sv
module sinv_l1_ctrl
  import sinv_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned WORDS       = 4,
  parameter int unsigned NUM_LINES   = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NUM_REGIONS = 4,
  localparam int unsigned OFF_W   = $clog2(WORDS),
  localparam int unsigned IDX_W   = $clog2(NUM_LINES),
  localparam int unsigned TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int unsigned LADDR_W = ADDR_W - OFF_W,
  localparam int unsigned RGN_W   = $clog2(NUM_REGIONS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic                     req_write_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  input  logic [RGN_W-1:0]         req_region_i,
  output logic                     req_ready_o,
  output logic                     rsp_valid_o,
  output logic [DATA_W-1:0]        rsp_data_o,
  output logic                     rd_req_valid_o,
  output logic [LADDR_W-1:0]       rd_req_line_o,
  input  logic                     fill_valid_i,
  input  logic [WORDS*DATA_W-1:0]  fill_data_i,
  input  logic [WORDS*RGN_W-1:0]   fill_region_i,
  output logic                     reg_valid_o,
  output logic [ADDR_W-1:0]        reg_addr_o,
  output logic [DATA_W-1:0]        reg_data_o,
  input  logic                     sweep_start_i,
  input  logic [NUM_REGIONS-1:0]   sweep_mask_i,
  output logic                     sweep_done_o
);
  ctrl_e             st_q;
  logic [ADDR_W-1:0] miss_q;
  logic              pend_q;

  logic             seq_busy, seq_last, seq_done, sweep_go;
  logic [IDX_W-1:0] seq_line;

  logic [ADDR_W-1:0] cur_addr;
  logic [OFF_W-1:0]  cur_off;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;

  logic [TAG_W-1:0]              l_tag [NUM_LINES];
  logic [WORDS-1:0][1:0]         l_st  [NUM_LINES];
  logic [WORDS-1:0][DATA_W-1:0]  l_dat [NUM_LINES];

  logic tag_hit, word_hit, acc, st_go, ld_hit, ld_miss, fill_go;

  assign cur_addr = (st_q == CS_WAIT) ? miss_q : req_addr_i;
  assign cur_off  = cur_addr[OFF_W-1:0];
  assign cur_idx  = cur_addr[OFF_W +: IDX_W];
  assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];

  assign tag_hit  = (l_tag[cur_idx] == cur_tag);
  assign word_hit = tag_hit && (l_st[cur_idx][cur_off] != 2'(WS_INV));

  assign sweep_go    = (sweep_start_i || pend_q) && (st_q == CS_IDLE) && !seq_busy;
  assign req_ready_o = (st_q == CS_IDLE) && !seq_busy && !sweep_start_i && !pend_q;
  assign acc         = req_valid_i && req_ready_o;
  assign st_go       = acc && req_write_i;
  assign ld_hit      = acc && !req_write_i && word_hit;
  assign ld_miss     = acc && !req_write_i && !word_hit;
  assign fill_go     = (st_q == CS_WAIT) && fill_valid_i;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic sel;
    assign sel = (cur_idx == IDX_W'(i));
    sinv_line #(
      .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W), .NUM_REGIONS(NUM_REGIONS)
    ) u_line (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     ((st_go || fill_go) && sel && !tag_hit),
      .tag_i       (cur_tag),
      .fill_i      (fill_go && sel),
      .fill_data_i (fill_data_i),
      .fill_rgn_i  (fill_region_i),
      .store_i     (st_go && sel),
      .touch_i     ((ld_hit || fill_go) && sel),
      .word_i      (cur_off),
      .wdata_i     (req_wdata_i),
      .wrgn_i      (req_region_i),
      .sweep_i     (seq_busy && seq_line == IDX_W'(i)),
      .mask_i      (sweep_mask_i),
      .clr_touch_i (seq_last),
      .tag_o       (l_tag[i]),
      .state_o     (l_st[i]),
      .data_o      (l_dat[i])
    );
  end

  sinv_sweep_seq #(.NUM_LINES(NUM_LINES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sweep_go),
    .busy_o  (seq_busy),
    .line_o  (seq_line),
    .last_o  (seq_last),
    .done_o  (seq_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= CS_IDLE;
      miss_q         <= '0;
      pend_q         <= 1'b0;
      rsp_valid_o    <= 1'b0;
      rsp_data_o     <= '0;
      rd_req_valid_o <= 1'b0;
      reg_valid_o    <= 1'b0;
      reg_addr_o     <= '0;
      reg_data_o     <= '0;
    end else begin
      rsp_valid_o    <= 1'b0;
      rd_req_valid_o <= 1'b0;
      reg_valid_o    <= 1'b0;
      // a start that cannot run now is remembered
      if (sweep_go)           pend_q <= 1'b0;
      else if (sweep_start_i) pend_q <= 1'b1;
      unique case (st_q)
        CS_IDLE: begin
          if (st_go) begin
            reg_valid_o <= 1'b1;
            reg_addr_o  <= req_addr_i;
            reg_data_o  <= req_wdata_i;
          end else if (ld_hit) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= l_dat[cur_idx][cur_off];
          end else if (ld_miss) begin
            miss_q         <= req_addr_i;
            rd_req_valid_o <= 1'b1;
            st_q           <= CS_WAIT;
          end
        end
        CS_WAIT: begin
          if (fill_valid_i) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= fill_data_i[cur_off*DATA_W +: DATA_W];
            st_q        <= CS_IDLE;
          end
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  assign rd_req_line_o = miss_q[ADDR_W-1:OFF_W];
  assign sweep_done_o  = seq_done;

  a_r4_store_registers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_write_i) |=>
      (reg_valid_o && reg_addr_o == $past(req_addr_i) && reg_data_o == $past(req_wdata_i)));
  a_r2_miss_requests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_miss |=> (rd_req_valid_o && !rsp_valid_o && rd_req_line_o == $past(req_addr_i[ADDR_W-1:OFF_W])));
  a_r3_hit_responds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hit |=> (rsp_valid_o && !rd_req_valid_o));
  a_r2_fill_responds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_go |=> rsp_valid_o);
  a_r10_quiet_in_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy |-> (!req_ready_o && !rd_req_valid_o && !reg_valid_o));
endmodule

// File: tb/sinv_l1_ctrl_test.sv
`timescale 1ns/1ps
module sinv_l1_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_region = '0;
  logic        req_ready, rsp_valid, rd_req_valid, reg_valid, sweep_done;
  logic [15:0] rsp_data, reg_data;
  logic [7:0]  rd_req_line;
  logic [9:0]  reg_addr;
  logic        fill_valid = 1'b0;
  logic [63:0] fill_data = '0;
  logic [7:0]  fill_region = '0;
  logic        sweep_start = 1'b0;
  logic [3:0]  sweep_mask = '0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sinv_l1_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_region_i(req_region), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .rd_req_valid_o(rd_req_valid), .rd_req_line_o(rd_req_line),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data), .fill_region_i(fill_region),
    .reg_valid_o(reg_valid), .reg_addr_o(reg_addr), .reg_data_o(reg_data),
    .sweep_start_i(sweep_start), .sweep_mask_i(sweep_mask), .sweep_done_o(sweep_done)
  );

  // {store, addr[10], data[16], miss, region[2], data_from_fill}
  typedef logic [30:0] vec_t;
  localparam int N_VEC = 6;
  localparam vec_t VECS [N_VEC] = '{
    {1'b0, 10'h000, 16'h0000, 1'b1, 2'd1, 1'b1},
    {1'b0, 10'h001, 16'h0000, 1'b0, 2'd1, 1'b1},
    {1'b1, 10'h002, 16'h1234, 1'b0, 2'd1, 1'b0},
    {1'b0, 10'h002, 16'h1234, 1'b0, 2'd1, 1'b0},
    {1'b0, 10'h005, 16'h0000, 1'b1, 2'd2, 1'b1},
    {1'b1, 10'h004, 16'h5555, 1'b0, 2'd2, 1'b0}
  };

  function automatic logic [15:0] fdata(input logic [7:0] la, input logic [1:0] w);
    return {4'hA, la, 2'b00, w};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_fill(input logic [7:0] la, input logic [1:0] rg);
    for (int w = 0; w < 4; w++) begin
      fill_data[w*16 +: 16] = fdata(la, 2'(w));
      fill_region[w*2 +: 2] = rg;
    end
    fill_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_load(input logic [9:0] a, input bit miss, input logic [15:0] exp_d,
                         input logic [1:0] rg, input string rq);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (miss) begin
      chk(rd_req_valid && !rsp_valid, rq, "read request on miss", {30'd0, rd_req_valid, rsp_valid}, 32'h2);
      chk(rd_req_line == a[9:2], rq, "read line", rd_req_line, a[9:2]);
      do_fill(a[9:2], rg);
    end else begin
      chk(!rd_req_valid && rsp_valid, rq, "hit without request", {30'd0, rd_req_valid, rsp_valid}, 32'h1);
    end
    chk(rsp_valid && rsp_data == exp_d, rq, "load data", {15'd0, rsp_valid, rsp_data}, {16'h1, exp_d});
  endtask

  task automatic do_store(input logic [9:0] a, input logic [15:0] d, input logic [1:0] rg,
                          input string rq);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_region = rg;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(reg_valid && reg_addr == a && reg_data == d, rq, "registration notice",
        {5'd0, reg_valid, reg_addr, reg_data}, {5'd0, 1'b1, a, d});
  endtask

  task automatic do_sweep(input logic [3:0] m);
    int n;
    wait_ready();
    sweep_start = 1'b1; sweep_mask = m;
    @(posedge clk);
    @(negedge clk);
    sweep_start = 1'b0;
    chk(!req_ready, "R10", "ready low during sweep", req_ready, 0);
    n = 0;
    while (!sweep_done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(n == 8, "R8", "cycles to done", n, 8);
    chk(req_ready, "R10", "ready after done", req_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !rd_req_valid && !reg_valid && !sweep_done, "R1",
        "reset outputs", {27'd0, req_ready, rsp_valid, rd_req_valid, reg_valid, sweep_done}, 32'h10);

    // vector walk: R2 misses, R3 hits, R4 stores
    for (int k = 0; k < N_VEC; k++) begin
      if (VECS[k][30])
        do_store(VECS[k][29:20], VECS[k][19:4], VECS[k][2:1], "R4");
      else
        do_load(VECS[k][29:20], VECS[k][3],
                VECS[k][0] ? fdata(VECS[k][29:22], VECS[k][21:20]) : VECS[k][19:4],
                VECS[k][2:1], VECS[k][3] ? "R2" : "R3");
    end

    // R5: fill merges only into Invalid words
    do_store(10'h009, 16'hBEEF, 2'd1, "R5");
    do_load(10'h008, 1'b1, fdata(8'h02, 2'd0), 2'd1, "R5");
    do_load(10'h009, 1'b0, 16'hBEEF, 2'd1, "R5");

    // R7/R8: sweep over region 1
    do_sweep(4'b0010);
    do_load(10'h003, 1'b1, fdata(8'h00, 2'd3), 2'd1, "R7");
    do_load(10'h002, 1'b0, 16'h1234, 2'd1, "R7");
    do_load(10'h000, 1'b0, fdata(8'h00, 2'd0), 2'd1, "R7");
    do_load(10'h006, 1'b0, fdata(8'h01, 2'd2), 2'd2, "R7");

    // R9: touched bits from the earlier phase no longer protect
    do_sweep(4'b0110);
    do_load(10'h001, 1'b1, fdata(8'h00, 2'd1), 2'd1, "R9");
    do_load(10'h000, 1'b0, fdata(8'h00, 2'd0), 2'd1, "R9");

    // R6: tag conflict reallocates the line
    do_store(10'h020, 16'h7777, 2'd3, "R6");
    do_load(10'h021, 1'b1, fdata(8'h08, 2'd1), 2'd3, "R6");
    do_load(10'h020, 1'b0, 16'h7777, 2'd3, "R6");
    do_load(10'h002, 1'b1, fdata(8'h00, 2'd2), 2'd3, "R6");

    // R10: sweep start and load in the same cycle
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'h004;
    sweep_start = 1'b1; sweep_mask = 4'hF;
    @(posedge clk);
    @(negedge clk);
    sweep_start = 1'b0;
    chk(!rsp_valid && !rd_req_valid, "R10", "load held behind sweep",
        {30'd0, rsp_valid, rd_req_valid}, 0);
    seen = 1'b0; n = 0;
    while (!rsp_valid && n < 40) begin
      if (sweep_done) seen = 1'b1;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(seen, "R10", "sweep done before response", seen, 1);
    chk(rsp_valid && rsp_data == 16'h5555, "R10", "held load data", rsp_data, 16'h5555);

    // R10: sweep start during an outstanding miss is deferred
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'h010;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rd_req_valid && rd_req_line == 8'h04, "R2", "miss line", rd_req_line, 8'h04);
    chk(!req_ready, "R10", "ready low during miss", req_ready, 0);
    sweep_start = 1'b1; sweep_mask = 4'b0001;
    @(posedge clk);
    @(negedge clk);
    sweep_start = 1'b0;
    chk(!sweep_done, "R10", "no sweep during miss", sweep_done, 0);
    do_fill(8'h04, 2'd0);
    chk(rsp_valid && rsp_data == fdata(8'h04, 2'd0), "R10", "fill completes first",
        rsp_data, fdata(8'h04, 2'd0));
    chk(!req_ready, "R10", "ready low while sweep pending", req_ready, 0);
    n = 0;
    while (!sweep_done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(sweep_done, "R10", "deferred sweep ran", sweep_done, 1);
    do_load(10'h011, 1'b1, fdata(8'h04, 2'd1), 2'd0, "R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule